// File: doc/BRIEF.md
# Frequency-Scaled System Counter

This block keeps a 64-bit count of elapsed time, measured in periods of a base-rate tick. It can run at a reduced update rate to save activity. In a slower mode it updates less often and adds a correspondingly larger step, so the value still tracks base-rate time. The supported rates are held in a table of 32-bit frequency words, given in Hz. Entry 0 is the base rate, and the table ends at the first entry that reads zero. Software reads the table, and can optionally write it, through a small register bus.

A mode change is requested with a one-cycle strobe and a table index. The block checks the request against the table in the cycle it arrives. A request it rejects raises a one-cycle error pulse and leaves everything as it was. A request it accepts is held as pending. The pending mode replaces the active one at the next base tick on which the update divider wraps, so no base period is lost or counted twice.

Top module: `fscale_counter`

## Requirements
- R1: Out of reset the count is 0 and the active mode index is 0. Table entry n holds BASE_FREQ >> n for n below INIT_ENTRIES, and 0 for every other entry.
- R2: Table entry n (0 to 39) sits at byte address 0x020 + 4*n. A read strobe (bus_en=1, bus_wr=0) returns that entry on bus_rdata in the cycle after the strobe.
- R3: A read returns zero when its address lies below 0x020, at or above 0x0C0, or has either of its two low bits set.
- R4: With TABLE_WRITABLE=1, a write strobe (bus_en=1, bus_wr=1) to a mapped address replaces that entry. With TABLE_WRITABLE=0, writes change no entry. Writes to unmapped addresses change nothing.
- R5: A mode request is accepted only when all of these hold:
  - the index is below 40;
  - no entry from 0 up to and including the index is zero;
  - the selected entry equals entry 0 shifted right by some k in 0..31, with that shift exact.
- R6: A rejected request sets mode_err to 1 for exactly the one cycle after the strobe. The active mode and any pending mode stay unchanged.
- R7: In a mode with shift k, the count grows by 2^k once every 2^k base ticks. The count does not change in a cycle without base_tick.
- R8: An accepted mode becomes active on the base tick where the divider wraps. That wrap still adds the old increment. cur_mode shows the new index from that same edge.
- R9: A later accepted request that arrives before the switch replaces the earlier pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mode_req | input | 1 | Mode change request strobe |
| mode_sel | input | 6 | Requested table index |
| base_tick | input | 1 | One pulse per base-rate period |
| count | output | 64 | System count value |
| cur_mode | output | 6 | Active table index |
| mode_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Every result is one register stage from its cause:
- bus_rdata and mode_err appear in the cycle after their strobe.
- count and cur_mode change at the edge that samples the wrapping base_tick.

The bench drives each input on a falling edge, deasserts it on the next falling edge, and samples outputs at that second falling edge, exactly one rising edge later. For the mode-switch boundary, the bench counts ticks inside an 8-tick period. It expects no change for seven ticks and the switch on the eighth.

// File: rtl/fscale_pkg.sv
package fscale_pkg;

  localparam int unsigned FREQ_W  = 32;
  localparam int unsigned SHIFT_W = 5;

  typedef struct packed {
    logic               ok;
    logic [SHIFT_W-1:0] sh;
  } ratio_t;

  // Finds k with sel == base >> k and sel << k == base (exact power-of-two divisor).
  function automatic ratio_t ratio_shift(input logic [FREQ_W-1:0] base,
                                         input logic [FREQ_W-1:0] sel);
    ratio_t r;
    r = '0;
    for (int k = 0; k < 2**SHIFT_W; k++) begin
      if (!r.ok && sel != '0 && (base >> k) == sel && (sel << k) == base) begin
        r.ok = 1'b1;
        r.sh = SHIFT_W'(k);
      end
    end
    return r;
  endfunction

  function automatic logic [FREQ_W-1:0] default_entry(input logic [FREQ_W-1:0] base,
                                                      input int idx, input int n_init);
    return (idx < n_init) ? (base >> idx) : '0;
  endfunction

endpackage

// File: rtl/fscale_table.sv
module fscale_table
  import fscale_pkg::*;
#(
  parameter int unsigned DEPTH        = 40,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BASE_ADDR    = 32'h020,
  parameter bit          WRITABLE     = 1'b1,
  parameter logic [FREQ_W-1:0] BASE_FREQ = 32'd100_000_000,
  parameter int unsigned INIT_ENTRIES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_en,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [FREQ_W-1:0]             bus_wdata,
  output logic [FREQ_W-1:0]             bus_rdata,
  output logic [DEPTH-1:0][FREQ_W-1:0]  entries
);

  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned SPAN  = 4 * DEPTH;

  logic [FREQ_W-1:0] tbl [DEPTH];
  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              wr_en;

  assign off = bus_addr - ADDR_W'(BASE_ADDR);
  assign hit = (bus_addr >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(SPAN)) && (off[1:0] == 2'b00);
  assign idx = off[IDX_W+1:2];

  generate
    if (WRITABLE) begin : g_rw
      assign wr_en = bus_en && bus_wr && hit;
    end else begin : g_ro
      assign wr_en = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= default_entry(BASE_FREQ, i, INIT_ENTRIES);
    end else if (wr_en) begin
      tbl[idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_en && !bus_wr) bus_rdata <= hit ? tbl[idx] : '0;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) entries[i] = tbl[i];
  end

  // R3: a read of an unmapped address yields zero
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_en && !bus_wr && !hit) |=> (bus_rdata == '0));

  generate
    if (!WRITABLE) begin : g_ro_chk
      // R4: read-only table ignores writes
      a_r4_ro_ignores_write: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr) |=> $stable(entries));
    end
  endgenerate

endmodule

// File: rtl/fscale_mode_ctl.sv
module fscale_mode_ctl
  import fscale_pkg::*;
#(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [DEPTH-1:0][FREQ_W-1:0] entries,
  input  logic                         mode_req,
  input  logic [IDX_W-1:0]             mode_sel,
  input  logic                         take,
  output logic                         pend_vld,
  output logic [IDX_W-1:0]             pend_idx,
  output logic [SHIFT_W-1:0]           pend_shift,
  output logic                         mode_err
);

  logic              in_range;
  logic              blocked;
  logic [FREQ_W-1:0] sel_freq;
  ratio_t            ratio;
  logic              accept;

  assign in_range = ({1'b0, mode_sel} < (IDX_W+1)'(DEPTH));

  // Any zero word at or before the requested index ends the table first.
  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((IDX_W'(i) <= mode_sel) && (entries[i] == '0)) blocked = 1'b1;
    end
  end

  assign sel_freq = in_range ? entries[mode_sel] : '0;
  assign ratio    = ratio_shift(entries[0], sel_freq);
  assign accept   = in_range && !blocked && ratio.ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld   <= 1'b0;
      pend_idx   <= '0;
      pend_shift <= '0;
      mode_err   <= 1'b0;
    end else begin
      mode_err <= mode_req && !accept;
      if (mode_req && accept) begin
        pend_vld   <= 1'b1;
        pend_idx   <= mode_sel;
        pend_shift <= ratio.sh;
      end else if (take) begin
        pend_vld <= 1'b0;
      end
    end
  end

  // R6: a rejected request leaves the pending mode untouched
  a_r6_reject_keeps_pending: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> ($stable(pend_idx) && $stable(pend_shift)));

  // R5: a rejection never creates a pending mode
  a_r5_reject_no_pending: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !$rose(pend_vld));

endmodule

// File: rtl/fscale_count.sv
module fscale_count
  import fscale_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               base_tick,
  input  logic               pend_vld,
  input  logic [IDX_W-1:0]   pend_idx,
  input  logic [SHIFT_W-1:0] pend_shift,
  output logic               take,
  output logic [CNT_W-1:0]   count,
  output logic [IDX_W-1:0]   cur_mode
);

  localparam int unsigned PH_W = 2**SHIFT_W;

  logic [PH_W-1:0]    phase;
  logic [PH_W-1:0]    last_ph;
  logic [SHIFT_W-1:0] cur_shift;
  logic               wrap;

  assign last_ph = (PH_W'(1) << cur_shift) - PH_W'(1);
  assign wrap    = base_tick && (phase == last_ph);
  assign take    = wrap && pend_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      phase     <= '0;
      cur_shift <= '0;
      cur_mode  <= '0;
    end else if (wrap) begin
      count <= count + (CNT_W'(1) << cur_shift);
      phase <= '0;
      if (pend_vld) begin
        cur_shift <= pend_shift;
        cur_mode  <= pend_idx;
      end
    end else if (base_tick) begin
      phase <= phase + PH_W'(1);
    end
  end

  // R7: no tick, no count change
  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(count));

  // R7: each update adds the increment of the mode active before it
  a_r7_step_size: assert property (@(posedge clk) disable iff (rst)
    !$stable(count) |-> ((count - $past(count)) == (CNT_W'(1) << $past(cur_shift))));

  // R8: the active mode only changes on a base tick
  a_r8_switch_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) |-> $past(base_tick));

  // R7: divider phase stays inside the current period
  a_r7_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phase <= last_ph);

endmodule

// File: rtl/fscale_counter.sv
module fscale_counter
  import fscale_pkg::*;
#(
  parameter int unsigned CNT_W          = 64,
  parameter int unsigned TBL_DEPTH      = 40,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned TBL_BASE       = 32'h020,
  parameter bit          TABLE_WRITABLE = 1'b1,
  parameter logic [31:0] BASE_FREQ      = 32'd100_000_000,
  parameter int unsigned INIT_ENTRIES   = 4,
  localparam int unsigned IDX_W         = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mode_req,
  input  logic [IDX_W-1:0]  mode_sel,
  input  logic              base_tick,
  output logic [CNT_W-1:0]  count,
  output logic [IDX_W-1:0]  cur_mode,
  output logic              mode_err
);

  logic [TBL_DEPTH-1:0][FREQ_W-1:0] entries;
  logic                             pend_vld;
  logic [IDX_W-1:0]                 pend_idx;
  logic [SHIFT_W-1:0]               pend_shift;
  logic                             take;

  fscale_table #(
    .DEPTH(TBL_DEPTH), .ADDR_W(ADDR_W), .BASE_ADDR(TBL_BASE),
    .WRITABLE(TABLE_WRITABLE), .BASE_FREQ(BASE_FREQ), .INIT_ENTRIES(INIT_ENTRIES)
  ) u_table (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .entries(entries)
  );

  fscale_mode_ctl #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_mode (
    .clk(clk), .rst(rst), .entries(entries), .mode_req(mode_req), .mode_sel(mode_sel),
    .take(take), .pend_vld(pend_vld), .pend_idx(pend_idx), .pend_shift(pend_shift),
    .mode_err(mode_err)
  );

  fscale_count #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_count (
    .clk(clk), .rst(rst), .base_tick(base_tick), .pend_vld(pend_vld),
    .pend_idx(pend_idx), .pend_shift(pend_shift), .take(take),
    .count(count), .cur_mode(cur_mode)
  );

  // R1: the first cycle out of reset shows a zero count in mode 0
  a_r1_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (count == '0 && cur_mode == '0 && !mode_err));

endmodule

// File: tb/fscale_counter_bench.sv
`timescale 1ns/1ps
module fscale_counter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_ro;
  logic        mode_req = 1'b0;
  logic [5:0]  mode_sel = '0;
  logic        base_tick = 1'b0;
  logic [63:0] count, count_ro;
  logic [5:0]  cur_mode, cur_mode_ro;
  logic        mode_err, mode_err_ro;

  always #4 clk = ~clk;

  fscale_counter u_fscale_counter (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .mode_req(mode_req), .mode_sel(mode_sel),
    .base_tick(base_tick), .count(count), .cur_mode(cur_mode), .mode_err(mode_err));

  fscale_counter #(.TABLE_WRITABLE(1'b0)) u_fscale_counter_ro (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_ro), .mode_req(1'b0), .mode_sel(6'd0),
    .base_tick(1'b0), .count(count_ro), .cur_mode(cur_mode_ro), .mode_err(mode_err_ro));

  int checks = 0;
  int errors = 0;

  // Reference model state
  longint unsigned m_cnt = 0;
  int m_ph = 0, m_sh = 0, m_mode = 0, m_pv = 0, m_psh = 0, m_pmode = 0;

  // {sel[5:0], accept, shift[4:0]} against the default table 100M,50M,25M,12.5M,0...
  localparam logic [11:0] VEC [7] = '{
    {6'd2,  1'b1, 5'd2}, {6'd4,  1'b0, 5'd0}, {6'd39, 1'b0, 5'd0},
    {6'd63, 1'b0, 5'd0}, {6'd1,  1'b1, 5'd1}, {6'd3,  1'b1, 5'd3},
    {6'd0,  1'b1, 5'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) base_tick = 1'b1;
    @(negedge clk) base_tick = 1'b0;
    m_ph++;
    if (m_ph == (1 << m_sh)) begin
      m_cnt += longint'(1) << m_sh;
      m_ph = 0;
      if (m_pv != 0) begin
        m_sh = m_psh; m_mode = m_pmode; m_pv = 0;
      end
    end
  endtask

  task automatic request(input int sel, input bit ok, input int sh, input string tag);
    @(negedge clk) begin mode_req = 1'b1; mode_sel = 6'(sel); end
    @(negedge clk) mode_req = 1'b0;
    check(tag, mode_err, !ok);
    if (ok) begin m_pv = 1; m_psh = sh; m_pmode = sel; end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk) begin bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
    @(negedge clk) begin bus_en = 1'b0; bus_wr = 1'b0; end
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk) begin bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; end
    @(negedge clk) bus_en = 1'b0;
  endtask

  task automatic align(input int mode);
    for (int n = 0; n < 200 && (m_mode != mode || m_ph != 0); n++) tick();
  endtask

  task automatic check_state(input string tag);
    check(tag, count, m_cnt);
    check(tag, cur_mode, 64'(m_mode));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    longint unsigned c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 count", count, 0);
    check("R1 mode", cur_mode, 0);
    check("R1 err", mode_err, 0);
    for (int i = 0; i < 6; i++) begin
      bus_read(12'h020 + 12'(4 * i));
      check("R1 R2 table default", rdata, (i < 4) ? (64'd100_000_000 >> i) : 64'd0);
    end
    bus_read(12'h024);
    check("R1 ro default", rdata_ro, 50_000_000);

    // R3: unmapped reads
    bus_read(12'h010); check("R3 below", rdata, 0);
    bus_read(12'h0C0); check("R3 above", rdata, 0);
    bus_read(12'h022); check("R3 unaligned", rdata, 0);

    // R2: last entry writable and read back; beyond it nothing sticks
    bus_write(12'h0BC, 32'd123);
    bus_read(12'h0BC); check("R2 last entry", rdata, 123);
    bus_write(12'h0C0, 32'd5);
    bus_read(12'h0C0); check("R3 R4 unmapped write", rdata, 0);

    // R5 R7 R8: vector walk
    for (int v = 0; v < 7; v++) begin
      request(int'(VEC[v][11:6]), VEC[v][5], int'(VEC[v][4:0]), "R5 vector");
      repeat (20) tick();
      check_state("R7 vector");
    end

    // R6: rejection pulse lasts one cycle, mode kept
    request(50, 1'b0, 0, "R6 reject");
    tick();
    check("R6 pulse ends", mode_err, 0);
    check_state("R6 mode kept");

    // R4: writable vs read-only
    bus_write(12'h030, 32'd30_000_000);
    bus_read(12'h030);
    check("R4 write", rdata, 30_000_000);
    check("R4 ro ignored", rdata_ro, 0);
    bus_write(12'h024, 32'd7);
    bus_read(12'h024);
    check("R4 ro entry1 kept", rdata_ro, 50_000_000);
    bus_write(12'h024, 32'd50_000_000);
    request(4, 1'b0, 0, "R5 non power-of-two divisor");
    bus_write(12'h030, 32'd6_250_000);
    request(4, 1'b1, 4, "R5 new entry");
    align(4);
    repeat (40) tick();
    check_state("R7 shift4");

    // R8: switch only at wrap, old increment on the wrap
    request(3, 1'b1, 3, "R5 mode3");
    align(3);
    c0 = m_cnt;
    repeat (3) tick();
    request(0, 1'b1, 0, "R5 mode0");
    check("R8 mid period count", count, c0);
    check("R8 mid period mode", cur_mode, 3);
    repeat (4) tick();
    check("R8 seventh tick", count, c0);
    tick();
    check("R8 wrap count", count, c0 + 8);
    check("R8 wrap mode", cur_mode, 0);
    tick();
    check("R7 base step", count, c0 + 9);

    // R9: later request replaces pending
    request(3, 1'b1, 3, "R5 mode3 again");
    align(3);
    repeat (2) tick();
    request(1, 1'b1, 1, "R9 first");
    request(2, 1'b1, 2, "R9 second");
    repeat (6) tick();
    check("R9 mode", cur_mode, 2);
    check_state("R9 state");

    // R5: zero entry in the middle ends the table
    bus_write(12'h028, 32'd0);
    request(3, 1'b0, 0, "R5 beyond terminator");
    bus_write(12'h028, 32'd25_000_000);
    request(3, 1'b1, 3, "R5 restored");
    align(3);
    repeat (16) tick();
    check_state("R7 final");

    summary();
    $finish;
  end

endmodule